// File: doc/BRIEF.md
# Dual-Mode Step Attenuator Control Register

This block holds the 6-bit control word of a digitally stepped attenuator with a 0.5 dB step and a 0 to 31.5 dB range. A mode pin chooses between two ways of loading the word. The first is a three-wire serial port with data, clock and latch enable. The second is a six-line parallel weight bus, which can be transparent or latched. A fast system clock samples every control input through a two-flop synchroniser. Rising edges of the serial clock and of the latch enable are detected in that clock domain. For correct edge capture, the system clock must run at least eight times faster than the serial clock.

When the synchronous reset is released, the word takes a preset value, and the source of that preset depends on the mode. In serial mode the preset is copied from the parallel weight lines. In parallel mode with latch enable low, the preset comes from a small table selected by two bits. In parallel mode with latch enable high, the preset is again the parallel word. After reset, the serial shift register and the parallel bus each load the output under their own latch-enable rule. A change of mode holds the output until the latch enable next rises in the new mode.

Top module: `atten_ctrl_top`

## Requirements
- R1: The mode input selects parallel control when 0 and serial control when 1. Bit k of the attenuation word weighs 0.5*2^k dB, so 6'b000000 is 0 dB, 6'b111111 is 31.5 dB, 6'b010000 is 8 dB and 6'b100000 is 16 dB.
- R2: In parallel mode, while latch enable is high and the mode is armed, the output follows the parallel inputs within 3 system clocks.
- R3: In parallel mode, changes on the parallel inputs while latch enable is low do not reach the output. A low-high-low latch enable pulse loads them.
- R4: In serial mode, each rising serial clock shifts one data bit into the shift register. The first bit shifted in ends at bit 5 (16 dB) and the last at bit 0 (0.5 dB). When more than six bits are sent, only the last six are kept.
- R5: In serial mode, the shift register is copied to the output while latch enable is high. The output holds while latch enable is low.
- R6: When reset is released in serial mode, the output equals the parallel inputs sampled during reset.
- R7: When reset is released in parallel mode with latch enable low, the preset is taken from the select bits {sel[1],sel[0]}: 00 gives 6'b000000, 01 gives 6'b010000, 10 gives 6'b100000 and 11 gives 6'b111110.
- R8: When reset is released in parallel mode with latch enable high, the output equals the parallel inputs.
- R9: In parallel mode, serial clock edges leave the shift register unchanged. A later serial load without clocks returns its old contents.
- R10: After any change of mode, the output keeps its value until latch enable rises in the new mode. This applies even when latch enable is already high at the moment of the change.
- R11: The edge detector produces exactly one shift per serial clock rising edge and never gives two adjacent pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| mode_serial_i | input | 1 | 0 = parallel control, 1 = serial control |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_clk_i | input | 1 | Serial clock, data taken on rising edge |
| latch_en_i | input | 1 | Latch enable for both modes |
| par_word_i | input | 6 | Parallel weight lines, bit k = 0.5*2^k dB |
| preset_sel_i | input | 2 | Parallel-mode reset preset select |
| atten_o | output | 6 | Registered attenuation word |

## Verification
On every cycle, the assertions check four properties. The output stays put while the synchronised latch enable is low. The shift register stays put in parallel mode. Each detected serial clock edge moves the register by exactly one bit, and edge pulses are never back to back. An armed serial transparent phase copies the shift register to the output. Only the bench scenarios can show the rest. These are the reset presets from each source, the bit order of a complete serial word, the last-six-bits rule, and the hold after a mode change with latch enable already high. They also cover a serial load after clocks that arrived in parallel mode, which must bring back the old register contents.

// File: rtl/atten_pkg.sv
package atten_pkg;
  parameter int unsigned ATT_W      = 6;
  parameter int unsigned SYNC_DEPTH = 2;
  parameter int unsigned SEL_W      = 2;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } ctrl_mode_e;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  // Reset loads the live input into every stage so no false edge follows reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= d_i;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/atten_rise.sv
module atten_rise #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= lvl_i;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] preset_i,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)             q_o <= preset_i;
    else if (shift_en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/atten_latch.sv
module atten_latch
  import atten_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_raw_i,
  input  logic         le_raw_i,
  input  logic [1:0]   sel_raw_i,
  input  logic [W-1:0] par_raw_i,
  input  logic         mode_s_i,
  input  logic         le_s_i,
  input  logic         le_rise_i,
  input  logic [W-1:0] par_s_i,
  input  logic [W-1:0] shreg_i,
  output logic         armed_o,
  output logic         mode_q_o,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] PRE_MID  = ONE << (W-2);
  localparam logic [W-1:0] PRE_HIGH = ONE << (W-1);
  localparam logic [W-1:0] PRE_TOP  = {W{1'b1}} ^ ONE;

  logic [W-1:0] reset_word;
  logic         mode_same;

  always_comb begin
    if (ctrl_mode_e'(mode_raw_i) == MODE_SER || le_raw_i) begin
      reset_word = par_raw_i;
    end else begin
      unique case (sel_raw_i)
        2'b01:   reset_word = PRE_MID;
        2'b10:   reset_word = PRE_HIGH;
        2'b11:   reset_word = PRE_TOP;
        default: reset_word = '0;
      endcase
    end
  end

  assign mode_same = (mode_s_i == mode_q_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q_o <= mode_raw_i;
      armed_o  <= 1'b1;
    end else if (!mode_same) begin
      mode_q_o <= mode_s_i;
      armed_o  <= 1'b0;
    end else if (le_rise_i) begin
      armed_o  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= reset_word;
    end else if (armed_o && le_s_i && mode_same) begin
      word_o <= (ctrl_mode_e'(mode_s_i) == MODE_SER) ? shreg_i : par_s_i;
    end
  end
endmodule

// File: rtl/atten_ctrl_top.sv
module atten_ctrl_top
  import atten_pkg::*;
#(
  parameter int unsigned W      = ATT_W,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_serial_i,
  input  logic         ser_data_i,
  input  logic         ser_clk_i,
  input  logic         latch_en_i,
  input  logic [W-1:0] par_word_i,
  input  logic [1:0]   preset_sel_i,
  output logic [W-1:0] atten_o
);
  localparam int unsigned SV_W = W + 4;

  logic [SV_W-1:0] sync_in, sync_out;
  logic            mode_s, le_s, sclk_s, sdata_s;
  logic [W-1:0]    par_s;
  logic [1:0]      rise_vec;
  logic            sclk_rise, le_rise;
  logic [W-1:0]    shreg_q;
  logic            armed, mode_q;

  assign sync_in = {mode_serial_i, latch_en_i, ser_clk_i, ser_data_i, par_word_i};

  atten_sync #(.W(SV_W), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(sync_in), .q_o(sync_out)
  );

  assign {mode_s, le_s, sclk_s, sdata_s, par_s} = sync_out;

  atten_rise #(.W(2)) rise_i (
    .clk(clk), .rst(rst), .lvl_i({le_s, sclk_s}), .rise_o(rise_vec)
  );

  assign sclk_rise = rise_vec[0];
  assign le_rise   = rise_vec[1];

  atten_shreg #(.W(W)) shreg_i (
    .clk(clk), .rst(rst), .preset_i(par_word_i),
    .shift_en_i(sclk_rise && (ctrl_mode_e'(mode_s) == MODE_SER)),
    .bit_i(sdata_s), .q_o(shreg_q)
  );

  atten_latch #(.W(W)) latch_i (
    .clk(clk), .rst(rst),
    .mode_raw_i(mode_serial_i), .le_raw_i(latch_en_i),
    .sel_raw_i(preset_sel_i), .par_raw_i(par_word_i),
    .mode_s_i(mode_s), .le_s_i(le_s), .le_rise_i(le_rise),
    .par_s_i(par_s), .shreg_i(shreg_q),
    .armed_o(armed), .mode_q_o(mode_q), .word_o(atten_o)
  );
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_s,
  input logic         mode_q,
  input logic         le_s,
  input logic         armed,
  input logic         sclk_rise,
  input logic [W-1:0] shreg_q,
  input logic [W-1:0] atten_o
);
  // R5 / R3: no load while the synchronised latch enable is low
  assert_hold_le_low_R5: assert property (@(posedge clk) disable iff (rst)
    !le_s |=> $stable(atten_o));

  // R9: parallel mode leaves the shift register untouched
  assert_shreg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !mode_s |=> $stable(shreg_q));

  // R4: a detected edge in serial mode moves the register by one place
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_s && sclk_rise) |=> (shreg_q[W-1:1] == $past(shreg_q[W-2:0])));

  // R11: edge pulses are single cycle
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);

  // R5: armed serial transparent phase copies the register to the output
  assert_ser_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_s && mode_q && le_s && armed) |=> (atten_o == $past(shreg_q)));
endmodule

bind atten_ctrl_top atten_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .mode_s(mode_s), .mode_q(mode_q), .le_s(le_s),
  .armed(armed), .sclk_rise(sclk_rise), .shreg_q(shreg_q), .atten_o(atten_o)
);

// File: tb/atten_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module atten_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0, sdata = 1'b0, sclk = 1'b0, le = 1'b0;
  logic [5:0] par = '0;
  logic [1:0] sel = '0;
  logic [5:0] atten;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  atten_ctrl_top dut_i (
    .clk(clk), .rst(rst), .mode_serial_i(mode), .ser_data_i(sdata),
    .ser_clk_i(sclk), .latch_en_i(le), .par_word_i(par),
    .preset_sel_i(sel), .atten_o(atten)
  );

  // {mode, le, sel[1:0], par[5:0], expected[5:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 2'b00, 6'b101010, 6'b000000},
    {1'b0, 1'b0, 2'b01, 6'b101010, 6'b010000},
    {1'b0, 1'b0, 2'b10, 6'b000001, 6'b100000},
    {1'b0, 1'b0, 2'b11, 6'b000001, 6'b111110},
    {1'b0, 1'b1, 2'b11, 6'b101010, 6'b101010},
    {1'b1, 1'b0, 2'b11, 6'b010101, 6'b010101}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    wait_n(2);
    sclk = 1'b1;
    wait_n(5);
    sclk = 1'b0;
    wait_n(5);
  endtask

  task automatic pulse_le();
    le = 1'b1;
    wait_n(8);
    le = 1'b0;
    wait_n(6);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // Reset presets walked from the table (R6, R7, R8)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      {mode, le, sel, par} = VEC[i][15:6];
      rst = 1'b1;
      wait_n(3);
      rst = 1'b0;
      wait_n(1);
      check(VEC[i][15] ? "R6 serial preset" :
            (VEC[i][14] ? "R8 parallel LE-high preset" : "R7 select preset"),
            atten, VEC[i][5:0]);
      wait_n(6);
      check("R7 preset held after release", atten, VEC[i][5:0]);
    end

    // Serial word, MSB first, held while LE low (R4, R5)
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    wait_n(4);
    check("R5 hold while LE low", atten, 6'b010101);
    pulse_le();
    check("R4 msb-first word", atten, 6'b101100);

    // Seven bits: only the last six kept (R4, R11)
    send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    send_bit(0); send_bit(1); send_bit(1);
    pulse_le();
    check("R11 last six bits kept", atten, 6'b100011);

    // All ones: 31.5 dB (R1)
    for (int k = 0; k < 6; k++) send_bit(1);
    pulse_le();
    check("R1 full scale word", atten, 6'b111111);

    // Mode change with LE low, then transparent parallel (R10, R2)
    par = 6'b000111;
    mode = 1'b0;
    wait_n(8);
    check("R10 no change after mode switch", atten, 6'b111111);
    le = 1'b1;
    wait_n(8);
    check("R2 transparent follow", atten, 6'b000111);
    par = 6'b110000;
    wait_n(6);
    check("R2 transparent second value", atten, 6'b110000);

    // Mode change while LE already high (R10)
    mode = 1'b1;
    wait_n(10);
    check("R10 LE-high mode switch holds", atten, 6'b110000);
    le = 1'b0;
    wait_n(4);
    mode = 1'b0;
    wait_n(6);

    // Latched parallel (R3)
    par = 6'b011011;
    wait_n(8);
    check("R3 ignored while LE low", atten, 6'b110000);
    pulse_le();
    check("R3 loaded by LE pulse", atten, 6'b011011);
    par = 6'b000000;
    wait_n(8);
    check("R3 holds after pulse", atten, 6'b011011);

    // Serial clocks in parallel mode are ignored (R9)
    for (int k = 0; k < 6; k++) send_bit(0);
    check("R9 output unchanged by clocks", atten, 6'b011011);
    mode = 1'b1;
    wait_n(6);
    pulse_le();
    check("R9 shift register untouched", atten, 6'b111111);

    finish_run();
  end
endmodule